// File: doc/BRIEF.md
# Clock Page Replacement Selector

This block picks the page frame to evict when a memory manager needs room for a new page. It follows the second-chance (clock) policy. Each of `NUM_FRAMES` frames carries one recently-used flag. A circular hand pointer marks where the next search begins. Any access to a frame raises that frame's flag, whether the access is a reference or a fresh load.

A search is started by a victim request. The search then walks the frames from the hand, one frame per clock cycle. It lowers every raised flag it passes. It stops at the first frame whose flag is already low, which becomes the victim. The hand then rests on the frame just after the victim, so the next search resumes there.

The victim request uses a valid/ready handshake. `vreq_ready` is high only while no search is running, so requests offered during a search are held off and not accepted. The result comes back as a one-cycle `victim_valid` strobe carrying `victim_frame`. The result has no back-pressure, so the requester must be ready to take it.

Top module: `clock_victim_sel`

## Requirements
- R1: Reset lowers every use flag and puts the hand on frame 0, so the first request after reset returns frame 0. After reset `vreq_ready` is 1 and `victim_valid` is 0.
- R2: A cycle with `touch_valid` = 1 raises the use flag of frame `touch_frame` at that clock edge. This covers both page references and page loads.
- R3: A request is accepted on a clock edge where `vreq_valid` and `vreq_ready` are both 1. `vreq_ready` is 0 from the cycle after acceptance until the cycle in which `victim_valid` is shown. A request offered while `vreq_ready` is 0 is ignored and produces no result.
- R4: During a search, the frame under the hand is examined once per cycle. If its flag is 1, the flag is lowered and the hand moves forward one frame.
- R5: The first examined frame whose flag is 0 is the victim. `victim_valid` is a one-cycle pulse with that index on `victim_frame`, shown k+1 clock edges after the accepting edge, where k is the number of raised flags passed.
- R6: After a victim is chosen, the hand points at the frame after it, wrapping from frame NUM_FRAMES-1 to frame 0. The next search starts there.
- R7: With no touches during a search, a victim is found in at most NUM_FRAMES+1 examined frames. When every flag is raised, the victim is the frame the search started on, reported 9 edges after acceptance for 8 frames.
- R8: If a touch and a search clear hit the same frame in the same cycle, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| touch_valid | input | 1 | Frame reference or load event |
| touch_frame | input | IDX_W | Frame index of the touch event |
| vreq_valid | input | 1 | Victim request valid |
| vreq_ready | output | 1 | Block is idle and can take a request |
| victim_valid | output | 1 | One-cycle strobe: victim chosen |
| victim_frame | output | IDX_W | Index of the chosen victim |

## Verification
The result latency depends on the flag pattern. `victim_valid` is due k+1 edges after the accepting edge, where k counts the raised flags passed, and `vreq_ready` drops one edge after acceptance. The bench keeps a model of the flags and the hand, so each driver call can compute the victim index and the exact bench cycle in which the strobe must appear. It queues both values. The monitor samples on the falling edge and compares the frame and the cycle number against the queue head. A strobe that arrives early, arrives late, or has no queued entry is therefore reported. For the collision case, the touch is timed to the first examined cycle, and the expected latency of ten edges follows from the forced second lap.

// File: rtl/clock_sel_pkg.sv
package clock_sel_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_e;
endpackage

// File: rtl/clk_use_bits.sv
module clk_use_bits #(
  parameter int NUM_FRAMES = 8,
  parameter int IDX_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  set_vld,
  input  logic [IDX_W-1:0]      set_idx,
  input  logic                  clr_vld,
  input  logic [IDX_W-1:0]      clr_idx,
  output logic [NUM_FRAMES-1:0] bits
);

  for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_flag
    logic hit_set, hit_clr;
    assign hit_set = set_vld && (set_idx == IDX_W'(i));
    assign hit_clr = clr_vld && (clr_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bits[i] <= 1'b0;
      else if (hit_set) bits[i] <= 1'b1;   // touch has priority over clear
      else if (hit_clr) bits[i] <= 1'b0;
    end
  end

  // R2
  touch_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_vld |=> bits[$past(set_idx)]);

  // R4
  pass_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vld && !(set_vld && set_idx == clr_idx)) |=> !bits[$past(clr_idx)]);

endmodule

// File: rtl/clk_hand.sv
module clk_hand #(
  parameter int NUM_FRAMES = 8,
  parameter int IDX_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [IDX_W-1:0] hand
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_FRAMES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hand <= '0;
    else if (step) hand <= (hand == LAST) ? '0 : hand + 1'b1;
  end

  // R6
  hand_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (hand == (($past(hand) == LAST) ? '0 : $past(hand) + 1'b1)));

  // R6
  hand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(hand));

endmodule

// File: rtl/clk_scan_fsm.sv
module clk_scan_fsm
  import clock_sel_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  parameter int IDX_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             cur_flag,
  input  logic [IDX_W-1:0] hand,
  output logic             step,
  output logic             clr_vld,
  output logic             victim_valid,
  output logic [IDX_W-1:0] victim_frame
);
  scan_state_e state, state_nx;
  logic        found;

  assign req_ready = (state == ST_IDLE);
  assign step      = (state == ST_SCAN);
  assign clr_vld   = (state == ST_SCAN) && cur_flag;
  assign found     = (state == ST_SCAN) && !cur_flag;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (req_valid) state_nx = ST_SCAN;
      ST_SCAN: if (found)     state_nx = ST_IDLE;
      default:                state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      victim_valid <= 1'b0;
      victim_frame <= '0;
    end else begin
      state        <= state_nx;
      victim_valid <= found;
      if (found) victim_frame <= hand;
    end
  end

  // R5
  victim_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |=> !victim_valid);

  // R3
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R3
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> req_ready);

endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int NUM_FRAMES = 8,
  parameter int IDX_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_valid,
  input  logic [IDX_W-1:0] touch_frame,
  input  logic             vreq_valid,
  output logic             vreq_ready,
  output logic             victim_valid,
  output logic [IDX_W-1:0] victim_frame
);
  localparam int RUN_W = IDX_W + 2;

  logic [NUM_FRAMES-1:0] use_flags;
  logic [IDX_W-1:0]      hand;
  logic                  step, clr_vld, cur_flag;

  assign cur_flag = use_flags[hand];

  clk_use_bits #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_vld(touch_valid), .set_idx(touch_frame),
    .clr_vld(clr_vld), .clr_idx(hand),
    .bits(use_flags)
  );

  clk_hand #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_hand (
    .clk(clk), .rst_n(rst_n), .step(step), .hand(hand)
  );

  clk_scan_fsm #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(vreq_valid), .req_ready(vreq_ready),
    .cur_flag(cur_flag), .hand(hand),
    .step(step), .clr_vld(clr_vld),
    .victim_valid(victim_valid), .victim_frame(victim_frame)
  );

  // Touch-free scan length counter, used only by the bound check below.
  logic [RUN_W-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     run_len <= '0;
    else if (!step || touch_valid)  run_len <= '0;
    else                            run_len <= run_len + 1'b1;
  end

  // R7
  scan_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (run_len <= RUN_W'(NUM_FRAMES)));

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (use_flags == '0 && hand == '0));

endmodule

// File: tb/clock_victim_sel_tb_top.sv
module clock_victim_sel_tb_top;
  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          touch_valid = 1'b0;
  logic [IW-1:0] touch_frame = '0;
  logic          vreq_valid = 1'b0;
  logic          vreq_ready;
  logic          victim_valid;
  logic [IW-1:0] victim_frame;

  always #10 clk = ~clk;

  clock_victim_sel #(.NUM_FRAMES(N), .IDX_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .touch_valid(touch_valid), .touch_frame(touch_frame),
    .vreq_valid(vreq_valid), .vreq_ready(vreq_ready),
    .victim_valid(victim_valid), .victim_frame(victim_frame)
  );

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    frame;
    int    due;
    string req;
  } exp_t;
  exp_t sb[$];

  logic [N-1:0] m_flags = '0;
  int           m_hand  = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: compares every strobe against the queue head.
  always @(negedge clk) begin
    if (rst_n && victim_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R3", "strobe with no accepted request", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(victim_frame == IW'(e.frame), e.req, "victim frame", int'(victim_frame), e.frame);
        check(cyc == e.due, e.req, "strobe cycle", cyc, e.due);
      end
    end
  end

  task automatic touch(int f);
    @(negedge clk);
    touch_valid = 1'b1;
    touch_frame = IW'(f);
    @(negedge clk);
    touch_valid = 1'b0;
    m_flags[f] = 1'b1;
  endtask

  task automatic request(string req, bit poke_busy);
    int k;
    int h;
    exp_t e;
    k = 0;
    h = m_hand;
    while (m_flags[h]) begin
      m_flags[h] = 1'b0;
      h = (h + 1) % N;
      k++;
    end
    m_hand = (h + 1) % N;
    @(negedge clk);
    e.frame = h;
    e.due   = cyc + k + 2;
    e.req   = req;
    sb.push_back(e);
    vreq_valid = 1'b1;
    @(negedge clk);
    vreq_valid = 1'b0;
    check(vreq_ready == 1'b0, "R3", "ready after accept", int'(vreq_ready), 0);
    if (poke_busy) vreq_valid = 1'b1;
    @(negedge clk);
    vreq_valid = 1'b0;
    repeat (k) @(negedge clk);
  endtask

  // R8: touch the start frame in the same cycle the scan clears it.
  task automatic collide_test();
    int h;
    exp_t e;
    h = m_hand;
    @(negedge clk);
    e.frame = (h + 1) % N;
    e.due   = cyc + 11;
    e.req   = "R8";
    sb.push_back(e);
    vreq_valid = 1'b1;
    @(negedge clk);
    vreq_valid  = 1'b0;
    touch_valid = 1'b1;
    touch_frame = IW'(h);
    @(negedge clk);
    touch_valid = 1'b0;
    repeat (9) @(negedge clk);
    m_flags = '0;
    m_hand  = (h + 2) % N;
  endtask

  initial begin
    logic [7:0] lfsr;
    lfsr = 8'hA5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(vreq_ready == 1'b1, "R1", "ready after reset", int'(vreq_ready), 1);
    check(victim_valid == 1'b0, "R1", "strobe after reset", int'(victim_valid), 0);
    request("R1", 1'b0);                       // frame 0, k=0
    touch(1); touch(2); touch(3);              // R2
    request("R4", 1'b0);                       // passes 1..3, victim 4
    touch(5); touch(6); touch(7); touch(0);
    request("R6", 1'b0);                       // wraps past 7, victim 1
    for (int f = 0; f < N; f++) touch(f);
    request("R7", 1'b0);                       // full lap, victim 2
    touch(4);
    request("R3", 1'b1);                       // busy-time request ignored
    repeat (4) @(negedge clk);
    for (int f = 0; f < N; f++) touch(f);
    collide_test();
    for (int it = 0; it < 20; it++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      for (int f = 0; f < N; f++) if (lfsr[f]) touch(f);
      request("R5", it[0]);
    end
    repeat (5) @(negedge clk);
    check(sb.size() == 0, "R5", "outstanding results", sb.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule